// File: doc/BRIEF.md
# Single-Cycle Register ALU Datapath with Not-Equal Branch

This block is the execution core of a simple processor. Each cycle it reads two registers from a small register file, routes them through two operand selectors into an arithmetic/logic unit, and can write the result back into a destination register on the next rising clock edge. The unit adds, subtracts and does bitwise logic. It reports zero, carry and signed-overflow flags.

The first operand can be forced to constant zero. The second operand can be a register, an immediate or constant one. With these sources, clear, increment, negate and load-immediate need no special opcode. A program counter advances by one every cycle. When the branch control is raised, it instead jumps to a supplied target whenever the ALU result is non-zero. The caller sets the ALU to subtract the two compared registers, so the branch is taken when they differ.

Every control signal is an input: operation code, selects, addresses, write enable and branch. Fetch and decode happen upstream.

Top module: `opsel_datapath`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted, the program counter is 0 and every register holds 0.
- R2: Two registers are read and one is written in the same cycle. The write takes effect at the rising clock edge, so a read of the register being written in that cycle returns its previous value.
- R3: Register 0 always reads as 0, and a write addressed to register 0 changes nothing.
- R4: `a_src_zero` = 0 feeds read port A to the ALU's first operand; `a_src_zero` = 1 feeds constant 0.
- R5: `b_src` selects the second operand: 2'b00 read port B, 2'b01 the immediate, 2'b10 or 2'b11 constant 1.
- R6: `alu_fn` codes: 0 add, 1 subtract (first minus second), 2 AND, 3 OR, 4 XOR, 5 NOR, 6 NOT of first operand; every other code passes the second operand through.
- R7: `flag_z` is 1 exactly when `alu_out` is all zeros, for every operation.
- R8: `flag_c` is the carry out of an add; on subtract it is 1 when no borrow occurs (first >= second, unsigned); it is 0 for all other codes.
- R9: `flag_v` is signed two's-complement overflow for add and subtract and 0 for all other codes.
- R10: With `br_ne` low, the program counter increments by 1 (modulo 2^PCW) at every rising edge.
- R11: With `br_ne` high, the program counter loads `br_target` when `flag_z` is 0 and increments by 1 when `flag_z` is 1.
- R12: When `wr_en` is high, `alu_out` is written into register `wr_sel` at the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_a | input | AW | Register index for read port A |
| rd_sel_b | input | AW | Register index for read port B |
| wr_sel | input | AW | Destination register index |
| wr_en | input | 1 | Write result to destination |
| a_src_zero | input | 1 | First operand: 0 port A, 1 constant zero |
| b_src | input | 2 | Second operand source select |
| alu_fn | input | 4 | ALU operation code |
| imm | input | W | Immediate operand |
| br_ne | input | 1 | Branch-if-not-equal this cycle |
| br_target | input | PCW | Branch destination |
| alu_out | output | W | ALU result |
| flag_z | output | 1 | Result is zero |
| flag_c | output | 1 | Carry / no-borrow |
| flag_v | output | 1 | Signed overflow |
| pc | output | PCW | Program counter |

## Verification
The hardest case to reach is a same-cycle collision. The register being written must also be read through a port, and the write must be visible only from the next cycle onward. The stimulus builds this on purpose: it first loads a known value through the immediate path, then increments that register in place and reads it in both cycles. The other hard cases are flag boundaries: signed overflow from the largest positive value, a borrow on negate, and equal operands for the branch. These are set up by directed loads through the immediate path before the random phase.

// File: rtl/dp_pkg.sv
package dp_pkg;
    localparam logic [3:0] FN_ADD  = 4'd0;
    localparam logic [3:0] FN_SUB  = 4'd1;
    localparam logic [3:0] FN_AND  = 4'd2;
    localparam logic [3:0] FN_OR   = 4'd3;
    localparam logic [3:0] FN_XOR  = 4'd4;
    localparam logic [3:0] FN_NOR  = 4'd5;
    localparam logic [3:0] FN_NOTA = 4'd6;

    localparam logic [1:0] BSRC_REG = 2'b00;
    localparam logic [1:0] BSRC_IMM = 2'b01;

    typedef struct packed {
        logic z;
        logic c;
        logic v;
    } flags_t;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
    parameter int W    = 16,
    parameter int NREG = 8,
    parameter int NRD  = 2,
    parameter int AW   = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NRD-1:0][AW-1:0] rd_sel,
    output logic [NRD-1:0][W-1:0]  rd_data,
    input  logic [AW-1:0]          wr_sel,
    input  logic                   wr_en,
    input  logic [W-1:0]           wr_data
);
    typedef struct packed {
        logic [NREG-1:0][W-1:0] regs;
    } rf_state_t;

    rf_state_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (wr_en && (wr_sel != '0)) begin
            rf_d.regs[wr_sel] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g] = (rd_sel[g] == '0) ? '0 : rf_q.regs[rd_sel[g]];
    end

    // R12
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel != '0)) |=> (rf_q.regs[$past(wr_sel)] == $past(wr_data)));

    // R3
    r0_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel[0] == '0) |-> (rd_data[0] == '0));
endmodule

// File: rtl/dp_opmux.sv
module dp_opmux #(
    parameter int W = 16
) (
    input  logic [W-1:0] port_a,
    input  logic [W-1:0] port_b,
    input  logic [W-1:0] imm,
    input  logic         a_src_zero,
    input  logic [1:0]   b_src,
    output logic [W-1:0] opnd_a,
    output logic [W-1:0] opnd_b
);
    import dp_pkg::*;

    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        opnd_a = a_src_zero ? '0 : port_a;
        case (b_src)
            BSRC_REG: opnd_b = port_b;
            BSRC_IMM: opnd_b = imm;
            default:  opnd_b = ONE;
        endcase
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic [3:0]    fn,
    output logic [W-1:0]  res,
    output dp_pkg::flags_t flags
);
    import dp_pkg::*;

    localparam int MSB = W - 1;

    logic [W:0] wide;

    always_comb begin
        wide    = '0;
        res     = '0;
        flags.c = 1'b0;
        flags.v = 1'b0;
        case (fn)
            FN_ADD: begin
                wide    = {1'b0, opnd_a} + {1'b0, opnd_b};
                res     = wide[W-1:0];
                flags.c = wide[W];
                flags.v = (opnd_a[MSB] == opnd_b[MSB]) && (res[MSB] != opnd_a[MSB]);
            end
            FN_SUB: begin
                wide    = {1'b0, opnd_a} + {1'b0, ~opnd_b} + (W+1)'(1);
                res     = wide[W-1:0];
                flags.c = wide[W];
                flags.v = (opnd_a[MSB] != opnd_b[MSB]) && (res[MSB] != opnd_a[MSB]);
            end
            FN_AND:  res = opnd_a & opnd_b;
            FN_OR:   res = opnd_a | opnd_b;
            FN_XOR:  res = opnd_a ^ opnd_b;
            FN_NOR:  res = ~(opnd_a | opnd_b);
            FN_NOTA: res = ~opnd_a;
            default: res = opnd_b;
        endcase
        flags.z = (res == '0);
    end
endmodule

// File: rtl/dp_pc.sv
module dp_pc #(
    parameter int PCW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           br_ne,
    input  logic           res_zero,
    input  logic [PCW-1:0] br_target,
    output logic [PCW-1:0] pc
);
    typedef struct packed {
        logic [PCW-1:0] pc;
    } pc_state_t;

    pc_state_t pc_d, pc_q;

    always_comb begin
        pc_d.pc = pc_q.pc + PCW'(1);
        if (br_ne && !res_zero) begin
            pc_d.pc = br_target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pc = pc_q.pc;

    // R10
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !br_ne) |=> (pc == $past(pc) + PCW'(1)));

    // R11
    pc_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && br_ne && !res_zero) |=> (pc == $past(br_target)));

    // R11
    pc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && br_ne && res_zero) |=> (pc == $past(pc) + PCW'(1)));
endmodule

// File: rtl/opsel_datapath.sv
module opsel_datapath #(
    parameter int W    = 16,
    parameter int NREG = 8,
    parameter int PCW  = 12,
    parameter int AW   = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  rd_sel_a,
    input  logic [AW-1:0]  rd_sel_b,
    input  logic [AW-1:0]  wr_sel,
    input  logic           wr_en,
    input  logic           a_src_zero,
    input  logic [1:0]     b_src,
    input  logic [3:0]     alu_fn,
    input  logic [W-1:0]   imm,
    input  logic           br_ne,
    input  logic [PCW-1:0] br_target,
    output logic [W-1:0]   alu_out,
    output logic           flag_z,
    output logic           flag_c,
    output logic           flag_v,
    output logic [PCW-1:0] pc
);
    import dp_pkg::*;

    localparam int NRD = 2;
    localparam int MSB = W - 1;

    logic [NRD-1:0][AW-1:0] rd_sel;
    logic [NRD-1:0][W-1:0]  rd_data;
    logic [W-1:0]           opnd_a, opnd_b;
    flags_t                 flags;

    assign rd_sel = {rd_sel_b, rd_sel_a};

    dp_regfile #(.W(W), .NREG(NREG), .NRD(NRD), .AW(AW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .wr_sel  (wr_sel),
        .wr_en   (wr_en),
        .wr_data (alu_out)
    );

    dp_opmux #(.W(W)) u_mux (
        .port_a     (rd_data[0]),
        .port_b     (rd_data[1]),
        .imm        (imm),
        .a_src_zero (a_src_zero),
        .b_src      (b_src),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b)
    );

    dp_alu #(.W(W)) u_alu (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .fn     (alu_fn),
        .res    (alu_out),
        .flags  (flags)
    );

    dp_pc #(.PCW(PCW)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .br_ne     (br_ne),
        .res_zero  (flags.z),
        .br_target (br_target),
        .pc        (pc)
    );

    assign flag_z = flags.z;
    assign flag_c = flags.c;
    assign flag_v = flags.v;

    // R4
    a_zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_src_zero && alu_fn == FN_ADD && b_src == BSRC_IMM) |-> (alu_out == imm));

    // R9
    ovf_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_fn == FN_ADD && flag_v) |-> (opnd_a[MSB] == opnd_b[MSB] && alu_out[MSB] != opnd_a[MSB]));

    // R8
    logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_fn != FN_ADD && alu_fn != FN_SUB) |-> (!flag_c && !flag_v));
endmodule

// File: tb/tb_opsel_datapath.sv
module tb_opsel_datapath;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 16;
    localparam int NREG = 8;
    localparam int PCW  = 12;
    localparam int AW   = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [AW-1:0]  rd_sel_a = '0, rd_sel_b = '0, wr_sel = '0;
    logic           wr_en = 1'b0, a_src_zero = 1'b0, br_ne = 1'b0;
    logic [1:0]     b_src = '0;
    logic [3:0]     alu_fn = '0;
    logic [W-1:0]   imm = '0;
    logic [PCW-1:0] br_target = '0;
    logic [W-1:0]   alu_out;
    logic           flag_z, flag_c, flag_v;
    logic [PCW-1:0] pc;

    int n_checks = 0;
    int n_fail   = 0;

    logic [W-1:0]   m_regs [NREG];
    logic [PCW-1:0] m_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    opsel_datapath #(.W(W), .NREG(NREG), .PCW(PCW), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .rd_sel_a(rd_sel_a), .rd_sel_b(rd_sel_b),
        .wr_sel(wr_sel), .wr_en(wr_en), .a_src_zero(a_src_zero), .b_src(b_src),
        .alu_fn(alu_fn), .imm(imm), .br_ne(br_ne), .br_target(br_target),
        .alu_out(alu_out), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v), .pc(pc)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // returns {v, c, result}
    function automatic logic [W+1:0] alu_ref(input logic [W-1:0] a, input logic [W-1:0] b,
                                              input logic [3:0] fn);
        logic [W:0]   s;
        logic [W-1:0] r;
        logic         c, v;
        s = '0; r = '0; c = 1'b0; v = 1'b0;
        case (fn)
            4'd0: begin s = {1'b0,a} + {1'b0,b}; r = s[W-1:0]; c = s[W];
                        v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]); end
            4'd1: begin r = a - b; c = (a >= b);
                        v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]); end
            4'd2: r = a & b;
            4'd3: r = a | b;
            4'd4: r = a ^ b;
            4'd5: r = ~(a | b);
            4'd6: r = ~a;
            default: r = b;
        endcase
        return {v, c, r};
    endfunction

    task automatic step(input string tag, input logic [AW-1:0] ra, input logic [AW-1:0] rb,
                        input logic [AW-1:0] wa, input logic we, input logic az,
                        input logic [1:0] bs, input logic [3:0] fn, input logic [W-1:0] im,
                        input logic bne, input logic [PCW-1:0] tgt);
        logic [W-1:0] ea, eb, er;
        logic [W+1:0] o;
        logic         ez;
        rd_sel_a = ra; rd_sel_b = rb; wr_sel = wa; wr_en = we; a_src_zero = az;
        b_src = bs; alu_fn = fn; imm = im; br_ne = bne; br_target = tgt;
        #2;
        ea = az ? '0 : m_regs[ra];
        eb = (bs == 2'b00) ? m_regs[rb] : (bs == 2'b01) ? im : W'(1);
        o  = alu_ref(ea, eb, fn);
        er = o[W-1:0];
        ez = (er == '0);
        check(tag, 32'(alu_out), 32'(er));
        check("R7 zero flag", 32'(flag_z), 32'(ez));
        check("R8 carry flag", 32'(flag_c), 32'(o[W]));
        check("R9 overflow flag", 32'(flag_v), 32'(o[W+1]));
        @(posedge clk);
        #1;
        if (we && wa != '0) m_regs[wa] = er;
        m_pc = (bne && !ez) ? tgt : m_pc + PCW'(1);
        check(bne ? "R11 branch pc" : "R10 pc step", 32'(pc), 32'(m_pc));
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < NREG; i++) m_regs[i] = '0;
        m_pc = '0;
        repeat (2) @(negedge clk);
        check("R1 pc in reset", 32'(pc), 32'd0);
        rst_n = 1'b1;
        // R1: registers cleared
        step("R1 reset regs", 3'd5, 3'd7, 3'd0, 1'b0, 1'b0, 2'b00, 4'd0, '0, 1'b0, '0);
        // R12 loads through immediate
        step("R12 load r1", 3'd0, 3'd0, 3'd1, 1'b1, 1'b1, 2'b01, 4'd0, 16'h7FFF, 1'b0, '0);
        step("R12 load r2", 3'd0, 3'd0, 3'd2, 1'b1, 1'b1, 2'b01, 4'd0, 16'h0001, 1'b0, '0);
        step("R12 load r3", 3'd0, 3'd0, 3'd3, 1'b1, 1'b1, 2'b01, 4'd0, 16'h1111, 1'b0, '0);
        step("R12 readback r1", 3'd1, 3'd0, 3'd0, 1'b0, 1'b0, 2'b00, 4'd0, '0, 1'b0, '0);
        // R3: write r0 ignored
        step("R3 write r0", 3'd0, 3'd0, 3'd0, 1'b1, 1'b1, 2'b01, 4'd0, 16'hABCD, 1'b0, '0);
        step("R3 read r0", 3'd0, 3'd0, 3'd0, 1'b0, 1'b1, 2'b00, 4'd0, '0, 1'b0, '0);
        // R4 clear / increment / negate
        step("R4 clear", 3'd1, 3'd1, 3'd0, 1'b0, 1'b1, 2'b10, 4'd2, '0, 1'b0, '0);
        step("R5 increment overflow", 3'd1, 3'd0, 3'd0, 1'b0, 1'b0, 2'b10, 4'd0, '0, 1'b0, '0);
        step("R5 const one code 3", 3'd0, 3'd0, 3'd0, 1'b0, 1'b1, 2'b11, 4'd0, '0, 1'b0, '0);
        step("R4 negate borrow", 3'd1, 3'd2, 3'd0, 1'b0, 1'b1, 2'b00, 4'd1, '0, 1'b0, '0);
        step("R8 sub no borrow", 3'd1, 3'd2, 3'd0, 1'b0, 1'b0, 2'b00, 4'd1, '0, 1'b0, '0);
        // R2: same-cycle write/read of r3 sees old value
        step("R2 read old", 3'd3, 3'd3, 3'd3, 1'b1, 1'b0, 2'b10, 4'd0, '0, 1'b0, '0);
        check("R2 model", 32'(m_regs[3]), 32'h1112);
        step("R2 read new", 3'd3, 3'd0, 3'd0, 1'b0, 1'b0, 2'b00, 4'd0, '0, 1'b0, '0);
        // R6 logic ops
        for (int f = 2; f < 16; f++) begin
            step("R6 op code", 3'd3, 3'd0, 3'd0, 1'b0, 1'b0, 2'b01, 4'(f), 16'h0F0F, 1'b0, '0);
        end
        // R11 branches
        step("R11 taken", 3'd1, 3'd2, 3'd0, 1'b0, 1'b0, 2'b00, 4'd1, '0, 1'b1, 12'h3A5);
        step("R11 not taken", 3'd2, 3'd2, 3'd0, 1'b0, 1'b0, 2'b00, 4'd1, '0, 1'b1, 12'h123);
        // random phase
        for (int i = 0; i < 400; i++) begin
            step("R6 random", AW'($urandom), AW'($urandom), AW'($urandom), 1'($urandom),
                 ($urandom % 4) == 0, 2'($urandom), 4'($urandom % 9), W'($urandom),
                 ($urandom % 5) == 0, PCW'($urandom));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule